// File: doc/BRIEF.md
# Cache Line Maintenance Sequencer

This block turns a single cache maintenance request into the ordered series of register writes and reads that a cache control unit expects. A request names an operation, a physical address, a virtual address and a byte length. The block widens the byte range outward to whole cache lines and counts the lines. It then issues one command per line, and a separate tag write before each command when the mode calls for one. Requests can instead target the whole cache, which takes a single command write.

Two addressing modes are supported. In legacy mode the page-index bits of the virtual address travel in the unused line-offset bits of the physical address, and that value is the only word written per line. In tagged mode the physical address goes to a tag register and the virtual address goes to the command register. A request that covers exactly one page-aligned page writes the tag only once.

Data-cache operations that write back wait for the cache to report that its flush is finished. They do this by polling a status bit in the control register. Flush-and-invalidate also switches the control register's invalidate mode to write-back before the commands, and switches it back after the wait. All register traffic leaves on a valid/ready write port and a valid/ready read port.

Top module: `cache_line_seq`

## Requirements
- R1: The operation codes are 1 for data invalidate, 2 for data write-back and 3 for data write-back-and-invalidate. Code 4 is instruction invalidate. The register identifiers on `wr_sel`/`rd_sel` are:
  - 1: data line invalidate
  - 2: data line write-back
  - 3: data tag
  - 4: instruction line invalidate
  - 5: instruction tag
  - 6: data control
  - 7: data whole invalidate
  - 8: data whole write-back
  - 9: instruction whole invalidate

  Codes 1 and 3 use register 1, code 2 uses register 2, and code 4 uses registers 4 and 5.
- R2: The line count is the ceiling of (length + physical address mod 32) / 32. The offset bits [4:0] of both addresses are cleared before the first line.
- R3: In legacy mode the block issues one command per line and no tag writes. The data is the aligned physical address with virtual address bits [17:13] placed in bits [4:0]. The data grows by 32 per line.
- R4: In tagged mode each line gets a tag write of the physical address, then a command write of the virtual address. Both addresses grow by 32 per line.
- R5: In tagged mode a request of length 8192 whose physical address has bits [12:0] equal to zero writes the tag once, before the first command. No other tag writes follow.
- R6: For code 3, the block first reads register 6. It then writes that value with bit 6 set, before any line or whole-cache command. After the status wait it writes the saved value with bit 6 cleared, as the last write.
- R7: For codes 2 and 3, after the last command the block keeps reading register 6 until a read returns bit 8 equal to 0.
- R8: With `whole` set, the line loop is replaced by a single write of the value 1 to register 7, 8 or 9, chosen by the operation. Mode handling and the status wait still apply as for lines.
- R9: A line request of length zero, or any operation code outside 1 to 4, makes no register access. Such a request raises `done` in the cycle after `start` is taken.
- R10: After reset `busy`, `done`, `wr_valid` and `rd_valid` are low. `start` is taken only while `busy` is low. `done` is a one-cycle pulse after the final access, and `busy` is low in the cycle after it.
- R11: A write stays on the port with stable `wr_sel` and `wr_data` until `wr_ready` is high. The block never has a read and a write pending in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken while idle |
| op | input | 3 | Operation code |
| whole | input | 1 | Operate on the entire cache |
| legacy | input | 1 | 1 selects legacy addressing, 0 selects tagged addressing |
| pa | input | AW | Physical start address |
| va | input | AW | Virtual start address |
| len | input | LEN_W | Length in bytes |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Write accepted |
| wr_sel | output | SELW | Register written |
| wr_data | output | AW | Write value |
| rd_valid | output | 1 | Register read pending |
| rd_ready | input | 1 | Read completes, `rd_data` valid |
| rd_sel | output | SELW | Register read |
| rd_data | input | AW | Read value |

## Verification
The bench builds the block with its default parameters. These are 32-byte lines, an 8 KB page, a 16-bit length and five stuffed index bits. With these values a length field can describe a full page, so the single-tag page case (256 lines) is reachable. The same page length at a misaligned address is also reachable, and the two can be compared line by line. The reference model drives the flush status busy for a chosen number of polls. Randomly withheld ready signals on both ports test that commands are held and that a `start` pulse arriving mid-request is ignored.

// File: rtl/cache_line_seq.sv
module cache_line_seq #(
  parameter int AW         = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 8192,
  parameter int STUFF_BITS = 5,
  parameter int SELW       = 4,
  parameter int MODE_BIT   = 6,
  parameter int STAT_BIT   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic            whole,
  input  logic            legacy,
  input  logic [AW-1:0]   pa,
  input  logic [AW-1:0]   va,
  input  logic [LEN_W-1:0] len,
  output logic            busy,
  output logic            done,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [SELW-1:0] wr_sel,
  output logic [AW-1:0]   wr_data,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [SELW-1:0] rd_sel,
  input  logic [AW-1:0]   rd_data
);
  localparam int OFFW = $clog2(LINE_BYTES);
  localparam int PGW  = $clog2(PAGE_BYTES);
  localparam int CW   = LEN_W + 1;

  localparam logic [SELW-1:0] SEL_DIVL = SELW'(1);
  localparam logic [SELW-1:0] SEL_DFLL = SELW'(2);
  localparam logic [SELW-1:0] SEL_DTAG = SELW'(3);
  localparam logic [SELW-1:0] SEL_IIVL = SELW'(4);
  localparam logic [SELW-1:0] SEL_ITAG = SELW'(5);
  localparam logic [SELW-1:0] SEL_DCTL = SELW'(6);
  localparam logic [SELW-1:0] SEL_DIVA = SELW'(7);
  localparam logic [SELW-1:0] SEL_DFLA = SELW'(8);
  localparam logic [SELW-1:0] SEL_IIVA = SELW'(9);

  localparam logic [AW-1:0] LINE_INC  = AW'(LINE_BYTES);
  localparam logic [AW-1:0] OFF_MASK  = AW'(LINE_BYTES - 1);
  localparam logic [AW-1:0] MODE_MASK = AW'(1) << MODE_BIT;

  typedef enum logic [3:0] {
    S_IDLE, S_RDCTL, S_SETM, S_PTAG, S_TAG, S_CMD, S_ALL, S_POLL, S_RST, S_DONE
  } st_t;

  st_t st;
  logic f_ic, f_inv, f_fl, f_mode, f_all, f_page, f_leg;
  logic [AW-1:0] pa_r, va_r, ctl;
  logic [CW-1:0] cnt;

  wire op_ok   = (op != 3'd0) && (op <= 3'd4);
  wire op_fl   = (op == 3'd2) || (op == 3'd3);
  wire no_work = !op_ok || (!whole && len == '0);
  wire [CW-1:0] sz     = CW'(len) + CW'(pa[OFFW-1:0]);
  wire [CW-1:0] nlines = (sz + CW'(LINE_BYTES - 1)) >> OFFW;
  wire page_op = !legacy && (len == LEN_W'(PAGE_BYTES)) && (pa[PGW-1:0] == '0);

  logic [AW-1:0] pa_al;
  always_comb begin
    pa_al = pa & ~OFF_MASK;
    if (legacy) pa_al[STUFF_BITS-1:0] = va[PGW +: STUFF_BITS];
  end

  function automatic st_t work_st(input logic all, input logic page, input logic leg);
    if (all)       return S_ALL;
    else if (page) return S_PTAG;
    else if (leg)  return S_CMD;
    else           return S_TAG;
  endfunction

  st_t after_st;
  assign after_st = f_fl ? S_POLL : S_DONE;

  wire wr_fire = wr_valid && wr_ready;
  wire rd_fire = rd_valid && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {f_ic, f_inv, f_fl, f_mode, f_all, f_page, f_leg} <= '0;
      pa_r <= '0;
      va_r <= '0;
      ctl  <= '0;
      cnt  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          f_ic   <= (op == 3'd4);
          f_inv  <= op[0];
          f_fl   <= op_fl;
          f_mode <= (op == 3'd3);
          f_all  <= whole;
          f_page <= page_op;
          f_leg  <= legacy;
          pa_r   <= pa_al;
          va_r   <= va & ~OFF_MASK;
          cnt    <= nlines;
          if (no_work)           st <= S_DONE;
          else if (op == 3'd3)   st <= S_RDCTL;
          else                   st <= work_st(whole, page_op, legacy);
        end
        S_RDCTL: if (rd_fire) begin
          ctl <= rd_data;
          st  <= S_SETM;
        end
        S_SETM: if (wr_fire) st <= work_st(f_all, f_page, f_leg);
        S_PTAG, S_TAG: if (wr_fire) st <= S_CMD;
        S_CMD: if (wr_fire) begin
          pa_r <= pa_r + LINE_INC;
          va_r <= va_r + LINE_INC;
          cnt  <= cnt - CW'(1);
          if (cnt == CW'(1))        st <= after_st;
          else if (f_page || f_leg) st <= S_CMD;
          else                      st <= S_TAG;
        end
        S_ALL: if (wr_fire) st <= after_st;
        S_POLL: if (rd_fire && !rd_data[STAT_BIT]) st <= f_mode ? S_RST : S_DONE;
        S_RST: if (wr_fire) st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);
  assign rd_valid = (st == S_RDCTL) || (st == S_POLL);
  assign rd_sel   = SEL_DCTL;
  assign wr_valid = (st == S_SETM) || (st == S_PTAG) || (st == S_TAG) ||
                    (st == S_CMD)  || (st == S_ALL)  || (st == S_RST);

  always_comb begin
    wr_sel  = '0;
    wr_data = '0;
    case (st)
      S_SETM: begin
        wr_sel  = SEL_DCTL;
        wr_data = ctl | MODE_MASK;
      end
      S_RST: begin
        wr_sel  = SEL_DCTL;
        wr_data = ctl & ~MODE_MASK;
      end
      S_PTAG, S_TAG: begin
        wr_sel  = f_ic ? SEL_ITAG : SEL_DTAG;
        wr_data = pa_r;
      end
      S_CMD: begin
        wr_sel  = f_ic ? SEL_IIVL : (f_inv ? SEL_DIVL : SEL_DFLL);
        wr_data = f_leg ? pa_r : va_r;
      end
      S_ALL: begin
        wr_sel  = f_ic ? SEL_IIVA : (f_inv ? SEL_DIVA : SEL_DFLA);
        wr_data = AW'(1);
      end
      default: ;
    endcase
  end
endmodule

module cache_line_seq_chk #(
  parameter int AW   = 32,
  parameter int SELW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic [SELW-1:0] wr_sel,
  input logic [AW-1:0]   wr_data,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic [SELW-1:0] rd_sel
);
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_sel) && $stable(wr_data)); // R11
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_valid)); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_sel)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R10
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid && !rd_valid && !done); // R10
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy); // R10
endmodule

bind cache_line_seq cache_line_seq_chk #(.AW(AW), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_sel(rd_sel)
);

// File: tb/cache_line_seq_test.sv
`timescale 1ns/1ps
module cache_line_seq_test;
  logic clk = 0, rst_n = 0, start = 0, whole = 0, legacy = 0;
  logic [2:0] op = 0;
  logic [31:0] pa = 0, va = 0, rd_data = 0;
  logic [15:0] len = 0;
  logic busy, done, wr_valid, rd_valid, wr_ready = 0, rd_ready = 0;
  logic [3:0] wr_sel, rd_sel;
  logic [31:0] wr_data;

  always #2.5 clk = ~clk;

  cache_line_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .whole(whole), .legacy(legacy),
    .pa(pa), .va(va), .len(len), .busy(busy), .done(done),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic        arm;
    logic [3:0]  sel;
    logic [31:0] data;
  } ent_t;

  ent_t q[$];
  int n_chk = 0, n_fail = 0, polls_left = 0, polls_k = 0;
  logic [31:0] ctrl_m = 32'h0000_0015;
  string cur = "reset";

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic a, input logic [3:0] s, input logic [31:0] d);
    ent_t e;
    e.kind = k; e.arm = a; e.sel = s; e.data = d;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      ent_t e;
      rd_data  = ctrl_m | (polls_left > 0 ? 32'h100 : 32'h0);
      wr_ready = ($urandom_range(0, 3) != 0);
      rd_ready = ($urandom_range(0, 2) != 0);
      if (wr_valid && wr_ready) begin
        if (q.size() == 0) chk(0, "R11 unexpected write", {wr_sel, wr_data}, 0);
        else begin
          e = q.pop_front();
          chk(e.kind == 0 && wr_sel == e.sel && wr_data == e.data, "R1 write",
              {wr_sel, wr_data}, {e.sel, e.data});
          if (wr_sel == 4'd6) ctrl_m = wr_data;
          if (e.arm) polls_left = polls_k;
        end
      end
      if (rd_valid && rd_ready) begin
        if (q.size() == 0) chk(0, "R7 unexpected read", rd_sel, 0);
        else begin
          e = q.pop_front();
          chk(e.kind != 0 && rd_sel == 4'd6, "R7 read", rd_sel, e.sel);
          if (polls_left > 0) polls_left--;
        end
      end
    end
  end

  task automatic run(input string name, input bit [2:0] o, input bit w, input bit lg,
                     input bit [31:0] p, input bit [31:0] v, input bit [15:0] l,
                     input int k, input bit poke);
    bit valid, fl, zero, page;
    logic [31:0] c0, pa_a, va_a;
    logic [3:0] csel, tsel;
    int n;
    cur = name;
    valid = (o >= 1 && o <= 4);
    fl = valid && (o == 2 || o == 3);
    zero = !valid || (!w && l == 0);
    polls_k = k;
    c0 = ctrl_m;
    if (!zero) begin
      if (o == 3) begin
        push(1, 0, 6, 0);
        push(0, 0, 6, c0 | 32'h40);
      end
      if (w) push(0, fl, (o == 4) ? 4'd9 : (o[0] ? 4'd7 : 4'd8), 32'd1);
      else begin
        n = (int'(l) + int'(p % 32) + 31) / 32;
        pa_a = p & ~32'h1f;
        va_a = v & ~32'h1f;
        page = !lg && l == 16'd8192 && (p % 8192) == 0;
        if (lg) pa_a = pa_a | ((v >> 13) & 32'h1f);
        csel = (o == 4) ? 4'd4 : (o[0] ? 4'd1 : 4'd2);
        tsel = (o == 4) ? 4'd5 : 4'd3;
        if (page) push(0, 0, tsel, pa_a);
        for (int i = 0; i < n; i++) begin
          if (!lg && !page) push(0, 0, tsel, pa_a);
          push(0, fl && i == n - 1, csel, lg ? pa_a : va_a);
          pa_a += 32;
          va_a += 32;
        end
      end
      if (fl) repeat (k + 1) push(2, 0, 6, 0);
      if (o == 3) push(0, 0, 6, c0 & ~32'h40);
    end
    @(negedge clk);
    op = o; whole = w; legacy = lg; pa = p; va = v; len = l; start = 1;
    @(negedge clk);
    start = 0;
    if (zero) chk(done == 1, "R9 done next cycle", done, 1);
    if (poke) begin
      start = 1; op = 3'd1; whole = 1;
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    chk(q.size() == 0, "all accesses issued", q.size(), 0);
    @(negedge clk);
    chk(!done && !busy, "R10 done single pulse", {done, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wr_valid && !rd_valid, "R10 reset state",
        {busy, done, wr_valid, rd_valid}, 0);
    rst_n = 1;
    run("R2 R4 tagged unaligned invalidate", 3'd1, 0, 0, 32'h1000_0013, 32'h0040_0013, 16'd40, 0, 0);
    run("R3 R7 legacy flush", 3'd2, 0, 1, 32'h2000_0044, 32'h0003_6008, 16'd64, 2, 0);
    run("R5 page tag once instruction", 3'd4, 0, 0, 32'h4000_2000, 32'h0012_2000, 16'd8192, 0, 0);
    run("R4 page length misaligned", 3'd1, 0, 0, 32'h4000_2020, 32'h0012_2020, 16'd8192, 0, 0);
    run("R6 flush-inv tagged", 3'd3, 0, 0, 32'h3000_0100, 32'h0060_0100, 16'd33, 3, 0);
    ctrl_m = 32'h0000_0055;
    run("R6 flush-inv legacy mode preset", 3'd3, 0, 1, 32'h3000_0000, 32'h0000_4000, 16'd1, 1, 0);
    run("R8 whole flush-inv", 3'd3, 1, 0, 32'h0, 32'h0, 16'd0, 1, 0);
    run("R8 whole flush", 3'd2, 1, 0, 32'h0, 32'h0, 16'd5, 0, 0);
    run("R8 whole data invalidate", 3'd1, 1, 0, 32'h0, 32'h0, 16'd0, 0, 0);
    run("R8 whole instruction invalidate", 3'd4, 1, 1, 32'h0, 32'h0, 16'd0, 0, 0);
    run("R9 zero length", 3'd2, 0, 0, 32'h5000_0000, 32'h0, 16'd0, 0, 0);
    run("R9 bad opcode", 3'd6, 0, 0, 32'h5000_0000, 32'h0, 16'd64, 0, 0);
    run("R10 start ignored while busy", 3'd2, 0, 1, 32'h6000_0008, 32'h0001_e000, 16'd100, 2, 1);
    run("R1 legacy instruction invalidate", 3'd4, 0, 1, 32'h7000_001f, 32'h0000_2000, 16'd2, 0, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule